// File: doc/BRIEF.md
# Epoch Backplane Transfer Allocator

This block decides, once per epoch, which source card may send to which destination card across a 15-port switched backplane. Each source card states which destinations it holds data for, and whether that card is a forwarding engine or a line card. Each destination card may raise a hold-off line when it cannot take more data. At every epoch boundary the block turns these inputs into a configuration with no conflicts: each source sends to at most one destination, and each destination takes data from at most one source.

The work is spread over four pipeline stages, each one epoch long:
1. The request matrix is captured at an epoch boundary.
2. The match is computed during the following epoch.
3. The result is issued to both the source side and the destination side of the cards.
4. One epoch later the same configuration is issued as the data-move stage, during which the two 64-byte units of each transfer cross the backplane.

The scan is greedy. Forwarding-engine sources are placed before line-card sources. Within each class, sources and destinations are tried in a rotated order. Two offsets, each drawn anew every epoch from a 16-bit LFSR, set the starting source and the starting destination, so no card number is preferred for good.

Requests and hold-off lines are level signals, sampled only at the boundary. A source keeps its request up until it sees a grant, so no handshake is needed on the request side. The configuration outputs are valid flags held for a whole epoch. Destinations cannot stall them directly: their only way to push back is the hold-off line, which keeps new grants away from them.

Top module: `bp_epoch_alloc`

## Requirements
- R1: An epoch lasts EPOCH_CYC (default 8) clock cycles. `epoch_strobe` is high in exactly the first cycle of each epoch, and every configuration output changes only in that cycle.
- R2: While reset is held and after it is released, all of `gnt_vld`, `dst_vld` and `xfer_vld` are 0 until the first configuration is issued.
- R3: No destination index appears in more than one valid source-side grant.
- R4: Requests are sampled in bit `req_mat[s*15+d]` (source s wants destination d). A request held steady over two boundaries appears, in the epoch after the second boundary, as `gnt_vld[s]` with `gnt_dst[s*4+:4]==d`. No grant is issued for a pair that was not requested.
- R5: A destination whose `inhibit` bit is high at a boundary gets no grant in the configuration issued at that boundary.
- R6: `fe_src[s]=1` marks source s as a forwarding engine. An unmatched forwarding-engine request to a destination that is not inhibited means that the destination went to another forwarding-engine source, or that the source itself was matched elsewhere.
- R7: The match is maximal: every sampled request whose destination is not inhibited ends up with its source or its destination matched.
- R8: When many sources contend for one destination in every epoch, the winner varies from epoch to epoch.
- R9: The destination-side outputs mirror the source side: `dst_vld[d]` with `dst_src[d*4+:4]==s` holds exactly when source s is granted destination d.
- R10: At each boundary, `xfer_vld`/`xfer_dst` take the configuration that was issued during the epoch that just ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Allocation clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_mat | input | 225 | Request bits, index s*15+d |
| fe_src | input | 15 | Source is a forwarding engine |
| inhibit | input | 15 | Destination hold-off |
| epoch_strobe | output | 1 | First cycle of an epoch |
| gnt_vld | output | 15 | Source-side grant valid |
| gnt_dst | output | 60 | Granted destination per source, 4 bits each |
| dst_vld | output | 15 | Destination-side notify valid |
| dst_src | output | 60 | Granting source per destination, 4 bits each |
| xfer_vld | output | 15 | Data-move stage valid per source |
| xfer_dst | output | 60 | Data-move destination per source |

## Verification
The assertions assume that `inhibit` is a clean level and that requests from a card stay valid long enough to reach a boundary. They relate grants only to what was sampled at that boundary, never to the values between boundaries. The stimulus changes requests, class bits and hold-off lines only on falling edges, and then holds them across at least three boundaries before any result is read. Because the rotation offsets are pseudo-random, the bench checks structural properties (conflicts, maximality, class priority, hold-off) and exact grant counts, not one fixed pairing. The exception is cases where only one answer is possible.

// File: rtl/bp_alloc_pkg.sv
package bp_alloc_pkg;
  localparam int PORTS_DEF = 15;
  localparam int IDX_W_DEF = 4;
  localparam int EPOCH_DEF = 8;

  // wrap-around add for a rotated scan position
  function automatic int rot_idx(input int pos, input int off, input int n);
    int r;
    r = pos + off;
    if (r >= n) r = r - n;
    return r;
  endfunction
endpackage

// File: rtl/bp_epoch_timer.sv
module bp_epoch_timer #(
  parameter int EPOCH_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic epoch_end,
  output logic epoch_strobe
);
  localparam int CW = (EPOCH_CYC > 1) ? $clog2(EPOCH_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(EPOCH_CYC - 1);

  logic [CW-1:0] tick_cnt;

  assign epoch_end = (tick_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt     <= '0;
      epoch_strobe <= 1'b0;
    end else begin
      tick_cnt     <= epoch_end ? '0 : tick_cnt + 1'b1;
      epoch_strobe <= epoch_end;
    end
  end
endmodule

// File: rtl/bp_shuffle_lfsr.sv
module bp_shuffle_lfsr #(
  parameter int NPORT = 15,
  parameter int IDXW  = 4,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  output logic [IDXW-1:0] src_off,
  output logic [IDXW-1:0] dst_off
);
  localparam logic [15:0] TAPS = 16'hB400;

  logic [15:0] state;

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= state[0] ? ((state >> 1) ^ TAPS) : (state >> 1);
  end

  assign src_off = IDXW'(int'(state[7:0])  % NPORT);
  assign dst_off = IDXW'(int'(state[15:8]) % NPORT);
endmodule

// File: rtl/bp_greedy_match.sv
module bp_greedy_match
  import bp_alloc_pkg::*;
#(
  parameter int NPORT = 15,
  parameter int IDXW  = 4
) (
  input  logic [NPORT*NPORT-1:0] req,
  input  logic [NPORT-1:0]       fe,
  input  logic [NPORT-1:0]       inh,
  input  logic [IDXW-1:0]        src_off,
  input  logic [IDXW-1:0]        dst_off,
  output logic [NPORT-1:0]       g_vld,
  output logic [NPORT*IDXW-1:0]  g_dst,
  output logic [NPORT-1:0]       d_vld,
  output logic [NPORT*IDXW-1:0]  d_src
);
  logic [NPORT-1:0] s_busy, d_busy;
  int s, d;

  // pass 0 places forwarding engines, pass 1 everyone left
  always_comb begin
    s_busy = '0;
    d_busy = '0;
    g_vld  = '0;
    g_dst  = '0;
    d_vld  = '0;
    d_src  = '0;
    s = 0;
    d = 0;
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < NPORT; i++) begin
        s = rot_idx(i, int'(src_off), NPORT);
        if (p == 1 || fe[s]) begin
          for (int j = 0; j < NPORT; j++) begin
            d = rot_idx(j, int'(dst_off), NPORT);
            if (!s_busy[s] && !d_busy[d] && !inh[d] && req[s*NPORT+d]) begin
              s_busy[s] = 1'b1;
              d_busy[d] = 1'b1;
              g_vld[s]  = 1'b1;
              g_dst[s*IDXW +: IDXW] = IDXW'(d);
              d_vld[d]  = 1'b1;
              d_src[d*IDXW +: IDXW] = IDXW'(s);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/bp_epoch_alloc.sv
module bp_epoch_alloc
  import bp_alloc_pkg::*;
#(
  parameter int NPORT     = PORTS_DEF,
  parameter int IDXW      = IDX_W_DEF,
  parameter int EPOCH_CYC = EPOCH_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT*NPORT-1:0] req_mat,
  input  logic [NPORT-1:0]       fe_src,
  input  logic [NPORT-1:0]       inhibit,
  output logic                   epoch_strobe,
  output logic [NPORT-1:0]       gnt_vld,
  output logic [NPORT*IDXW-1:0]  gnt_dst,
  output logic [NPORT-1:0]       dst_vld,
  output logic [NPORT*IDXW-1:0]  dst_src,
  output logic [NPORT-1:0]       xfer_vld,
  output logic [NPORT*IDXW-1:0]  xfer_dst
);
  logic                   epoch_end;
  logic [IDXW-1:0]        src_off, dst_off;
  logic [NPORT*NPORT-1:0] req_q;
  logic [NPORT-1:0]       fe_q;
  logic [NPORT-1:0]       m_gvld, m_dvld;
  logic [NPORT*IDXW-1:0]  m_gdst, m_dsrc;

  bp_epoch_timer #(.EPOCH_CYC(EPOCH_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .epoch_end(epoch_end), .epoch_strobe(epoch_strobe)
  );

  bp_shuffle_lfsr #(.NPORT(NPORT), .IDXW(IDXW)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(epoch_end),
    .src_off(src_off), .dst_off(dst_off)
  );

  bp_greedy_match #(.NPORT(NPORT), .IDXW(IDXW)) u_match (
    .req(req_q), .fe(fe_q), .inh(inhibit),
    .src_off(src_off), .dst_off(dst_off),
    .g_vld(m_gvld), .g_dst(m_gdst), .d_vld(m_dvld), .d_src(m_dsrc)
  );

  // stage registers all move on the boundary edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= '0;
      fe_q     <= '0;
      gnt_vld  <= '0;
      gnt_dst  <= '0;
      dst_vld  <= '0;
      dst_src  <= '0;
      xfer_vld <= '0;
      xfer_dst <= '0;
    end else if (epoch_end) begin
      req_q    <= req_mat;
      fe_q     <= fe_src;
      gnt_vld  <= m_gvld;
      gnt_dst  <= m_gdst;
      dst_vld  <= m_dvld;
      dst_src  <= m_dsrc;
      xfer_vld <= gnt_vld;
      xfer_dst <= gnt_dst;
    end
  end
endmodule

// File: rtl/bp_epoch_alloc_chk.sv
module bp_epoch_alloc_chk #(
  parameter int NPORT = 15,
  parameter int IDXW  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NPORT-1:0]      inhibit,
  input logic                  epoch_strobe,
  input logic [NPORT-1:0]      gnt_vld,
  input logic [NPORT*IDXW-1:0] gnt_dst,
  input logic [NPORT-1:0]      dst_vld,
  input logic [NPORT*IDXW-1:0] dst_src,
  input logic [NPORT-1:0]      xfer_vld
);
  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch_strobe |-> ($stable(gnt_vld) && $stable(dst_vld) && $stable(xfer_vld)));

  // R10
  xfer_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_strobe |-> (xfer_vld == $past(gnt_vld)));

  for (genvar d = 0; d < NPORT; d++) begin : g_dst
    logic [NPORT-1:0] hits;
    always_comb
      for (int s = 0; s < NPORT; s++)
        hits[s] = gnt_vld[s] && (gnt_dst[s*IDXW +: IDXW] == IDXW'(d));

    // R3
    dst_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hits));

    // R5
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (epoch_strobe && $past(inhibit[d])) |-> !dst_vld[d]);

    // R9
    mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dst_vld[d] == (hits != '0));
  end

  for (genvar s = 0; s < NPORT; s++) begin : g_src
    // R9
    back_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld[s] |-> (dst_src[int'(gnt_dst[s*IDXW +: IDXW])*IDXW +: IDXW] == IDXW'(s)));
  end
endmodule

bind bp_epoch_alloc bp_epoch_alloc_chk #(.NPORT(NPORT), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .epoch_strobe(epoch_strobe),
  .gnt_vld(gnt_vld), .gnt_dst(gnt_dst), .dst_vld(dst_vld), .dst_src(dst_src),
  .xfer_vld(xfer_vld)
);

// File: tb/bp_epoch_alloc_test.sv
module bp_epoch_alloc_test;
  localparam int N = 15;
  localparam int W = 4;

  typedef struct packed {
    logic [2:0]   kind;  // 0 single,1 all,2 shift perm,3 contested,4 empty
    logic [3:0]   a;
    logic [3:0]   b;
    logic [N-1:0] fe;
    logic [N-1:0] inh;
    logic [4:0]   cnt;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{3'd0, 4'd4,  4'd7, 15'h0000, 15'h0000, 5'd1},
    '{3'd0, 4'd14, 4'd0, 15'h0000, 15'h0000, 5'd1},
    '{3'd0, 4'd5,  4'd5, 15'h0000, 15'h0020, 5'd0},
    '{3'd1, 4'd0,  4'd0, 15'h0000, 15'h0000, 5'd15},
    '{3'd1, 4'd0,  4'd0, 15'h0F0F, 15'h0007, 5'd12},
    '{3'd2, 4'd3,  4'd0, 15'h0000, 15'h0000, 5'd15},
    '{3'd2, 4'd1,  4'd0, 15'h00FF, 15'h0000, 5'd15},
    '{3'd3, 4'd0,  4'd3, 15'h0200, 15'h0000, 5'd1},
    '{3'd4, 4'd0,  4'd0, 15'h7FFF, 15'h0000, 5'd0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N*N-1:0]   req_mat = '0;
  logic [N-1:0]     fe_src = '0;
  logic [N-1:0]     inhibit = '0;
  logic             epoch_strobe;
  logic [N-1:0]     gnt_vld, dst_vld, xfer_vld;
  logic [N*W-1:0]   gnt_dst, dst_src, xfer_dst;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bp_epoch_alloc uut (
    .clk(clk), .rst_n(rst_n), .req_mat(req_mat), .fe_src(fe_src),
    .inhibit(inhibit), .epoch_strobe(epoch_strobe), .gnt_vld(gnt_vld),
    .gnt_dst(gnt_dst), .dst_vld(dst_vld), .dst_src(dst_src),
    .xfer_vld(xfer_vld), .xfer_dst(xfer_dst)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [N*N-1:0] build(input vec_t v);
    logic [N*N-1:0] r = '0;
    case (v.kind)
      3'd0: r[int'(v.a)*N + int'(v.b)] = 1'b1;
      3'd1: r = '1;
      3'd2: for (int s = 0; s < N; s++) r[s*N + ((s + int'(v.a)) % N)] = 1'b1;
      3'd3: begin
        r[2*N + int'(v.b)] = 1'b1;
        r[9*N + int'(v.b)] = 1'b1;
        r[12*N + int'(v.b)] = 1'b1;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic wait_strobes(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (!epoch_strobe) @(negedge clk);
    end
  endtask

  function automatic int dst_of(input int s);
    return int'(gnt_dst[s*W +: W]);
  endfunction

  // property checks on the configuration now held at the outputs
  task automatic check_cfg(input int exp_cnt, input int idx);
    int cnt = 0;
    bit conflict = 0, spurious = 0, hold_off = 0, not_max = 0, prio = 0, mirror = 0;
    logic [N-1:0] dtaken = '0;
    logic [N-1:0] dfe = '0;
    for (int s = 0; s < N; s++) if (gnt_vld[s]) begin
      cnt++;
      if (dtaken[dst_of(s)]) conflict = 1;
      dtaken[dst_of(s)] = 1'b1;
      if (fe_src[s]) dfe[dst_of(s)] = 1'b1;
      if (!req_mat[s*N + dst_of(s)]) spurious = 1;
      if (inhibit[dst_of(s)]) hold_off = 1;
    end
    for (int d = 0; d < N; d++)
      if (dst_vld[d] != dtaken[d] ||
          (dst_vld[d] && !(gnt_vld[int'(dst_src[d*W +: W])] &&
                           dst_of(int'(dst_src[d*W +: W])) == d))) mirror = 1;
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++)
        if (req_mat[s*N+d] && !inhibit[d]) begin
          if (!gnt_vld[s] && !dtaken[d]) not_max = 1;
          if (fe_src[s] && !gnt_vld[s] && !dfe[d]) prio = 1;
        end
    chk(cnt == exp_cnt, $sformatf("R4 count vec%0d", idx), cnt, exp_cnt);
    chk(!conflict, $sformatf("R3 vec%0d", idx), conflict, 0);
    chk(!spurious, $sformatf("R4 unrequested vec%0d", idx), spurious, 0);
    chk(!hold_off, $sformatf("R5 vec%0d", idx), hold_off, 0);
    chk(!not_max, $sformatf("R7 vec%0d", idx), not_max, 0);
    chk(!prio, $sformatf("R6 vec%0d", idx), prio, 0);
    chk(!mirror, $sformatf("R9 vec%0d", idx), mirror, 0);
  endtask

  initial begin
    logic [N-1:0]   snap_v;
    logic [N*W-1:0] snap_d;
    logic [N-1:0]   winners;
    int cyc;
    repeat (3) @(negedge clk);
    // R2: outputs cleared while in reset
    chk(gnt_vld == '0 && dst_vld == '0 && xfer_vld == '0, "R2 in reset",
        int'(gnt_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gnt_vld == '0 && xfer_vld == '0, "R2 after release", int'(gnt_vld), 0);

    // R1: epoch length
    wait_strobes(1);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!epoch_strobe);
    chk(cyc == 8, "R1 epoch length", cyc, 8);

    // R4: pipeline latency; request visible only after two boundaries
    req_mat = '0;
    req_mat[6*N + 11] = 1'b1;
    wait_strobes(1);
    chk(gnt_vld == '0, "R4 latency early", int'(gnt_vld), 0);
    wait_strobes(1);
    chk(gnt_vld[6] && dst_of(6) == 11, "R4 latency grant", dst_of(6), 11);

    for (int v = 0; v < NV; v++) begin
      req_mat = build(VT[v]);
      fe_src  = VT[v].fe;
      inhibit = VT[v].inh;
      wait_strobes(3);
      check_cfg(int'(VT[v].cnt), v);
      snap_v = gnt_vld;
      snap_d = gnt_dst;
      wait_strobes(1);
      // R10
      chk(xfer_vld == snap_v && xfer_dst == snap_d,
          $sformatf("R10 vec%0d", v), int'(xfer_vld), int'(snap_v));
    end

    // R6: contested destination, forwarding engine 9 must win
    req_mat = build(VT[7]);
    fe_src  = 15'h0200;
    inhibit = '0;
    wait_strobes(3);
    chk(gnt_vld == 15'h0200 && dst_of(9) == 3, "R6 fe winner", int'(gnt_vld), 'h200);

    // R5: inhibit lifted lets the held request through
    req_mat = '0;
    req_mat[1*N + 8] = 1'b1;
    fe_src  = '0;
    inhibit = 15'h0100;
    wait_strobes(3);
    chk(!gnt_vld[1], "R5 held off", int'(gnt_vld[1]), 0);
    inhibit = '0;
    wait_strobes(2);
    chk(gnt_vld[1] && dst_of(1) == 8, "R5 released", dst_of(1), 8);

    // R8: all sources want destination 0, winner must rotate
    req_mat = '0;
    for (int s = 0; s < N; s++) req_mat[s*N] = 1'b1;
    wait_strobes(3);
    winners = '0;
    for (int e = 0; e < 20; e++) begin
      winners |= gnt_vld;
      chk($countones(gnt_vld) == 1, "R8 one winner", $countones(gnt_vld), 1);
      wait_strobes(1);
    end
    chk($countones(winners) >= 3, "R8 distinct winners", $countones(winners), 3);

    // R2: reset mid-run clears configuration
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(gnt_vld == '0 && dst_vld == '0 && xfer_vld == '0, "R2 re-reset",
        int'(gnt_vld), 0);
    rst_n = 1'b1;

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule